// File: doc/BRIEF.md
# Stack and Interrupt Control Sequencer

This block is the part of an 8-bit processor core that moves values between the core and the hardware stack. It handles subroutine entry and exit, the software break trap, return from interrupt, and the four single-byte stack transfers. The core presents one command as a one-hot pulse, together with its current program counter, the call target, the accumulator and the six status flags. The sequencer then runs the byte-wide bus reads and writes the command needs, one per cycle. It keeps the 8-bit stack pointer and reports the new program counter, flags or accumulator with a one-cycle done pulse.

The status byte that goes onto the stack always carries a set break bit and a set bit 5. When a status byte is pulled, those two bits are dropped and the interrupt-disable flag is cleared. After reset the sequencer fetches the start address from the reset vector by itself, and it accepts no command until it is idle.

Top module: `stk_seq`

## Requirements
- R1: A pushed status byte holds, from bit 0 up: C, Z, I, D, a 1 for break, a 1 in bit 5, V, N. The flags ports carry the flags as bit 0 C, bit 1 Z, bit 2 I, bit 3 D, bit 4 V, bit 5 N.
- R2: When a status byte is pulled (pull-status or interrupt return), bits 4 and 5 are ignored and I is forced to 0. C, Z, D, V and N take bits 0, 1, 3, 6 and 7.
- R3: Call (cmd bit 0) pushes pc_i minus one, high byte first, then loads target_i into the program counter. done_o rises 3 clock edges after the accepting edge, counting that edge.
- R4: Return (cmd bit 1) pulls the low byte and then the high byte, and loads that value plus one into the program counter. Latency 4.
- R5: Break (cmd bit 2) pushes pc_i minus one (high byte first) and then the status byte. It loads the program counter from 0xFFFE (low byte) and 0xFFFF (high byte) and reports the flags with I set. Latency 7.
- R6: Interrupt return (cmd bit 3) pulls the status byte, then the low and high address bytes, and loads the address unchanged. Latency 5.
- R7: Push accumulator (cmd bit 4) and push status (cmd bit 5) each write one byte. Latency 2.
- R8: Pull accumulator (cmd bit 6) loads the byte into acc_o and reports flags_i with Z and N taken from that byte. Pull status (cmd bit 7) loads the flags as in R2. Both have latency 3.
- R9: The stack sits at 0x0100 plus the stack pointer. A push writes at the current pointer and then decrements it. A pull increments the pointer and then reads. The pointer wraps modulo 256.
- R10: Reset sets the stack pointer to 0xFD. The sequencer then reads 0xFFFC and 0xFFFD and loads the program counter from them, little-endian. done_o rises on the third edge after reset is released.
- R11: A command is taken only while busy_o is low and only if exactly one cmd bit is set. Any other pattern causes no bus access, no pointer change and no done pulse.
- R12: done_o lasts one cycle and falls in idle. The load strobes pulse only together with done_o. Read and write strobes are never active together, and neither is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 8 | One-hot command: call, return, break, interrupt return, push acc, push status, pull acc, pull status (bit 0 up) |
| pc_i | input | 16 | Program counter past the instruction's operand bytes |
| target_i | input | 16 | Call destination |
| acc_i | input | 8 | Accumulator value to push |
| flags_i | input | 6 | Current flags {N,V,D,I,Z,C} |
| mem_rd_o | output | 1 | Read strobe; data returns on mem_rdata_i one cycle later |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | 16 | Bus address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | A command or reset fetch is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | New program counter |
| pc_load_o | output | 1 | pc_o is to be taken (with done_o) |
| flags_o | output | 6 | New flags {N,V,D,I,Z,C} |
| flags_load_o | output | 1 | flags_o is to be taken (with done_o) |
| acc_o | output | 8 | Pulled accumulator |
| acc_load_o | output | 1 | acc_o is to be taken (with done_o) |

## Verification
Two cases are the hardest to reach from the ports. One is a stack pointer that wraps through 0x00 and 0xFF in the middle of a multi-byte command. The other is a command offered while a long break sequence is still running. The stimulus reaches the first with a directed run of 256 pushes followed by 256 pulls. It reaches the second by raising a push request in the middle of a break and checking that the pointer and the stack image match a model that never saw the request. Seeded random command streams, with random program counters, flags and accumulator values, then exercise packing and unpacking across many byte patterns.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int CMD_N  = 8;
    localparam int OP_W   = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [OP_W-1:0] {
        OP_CALL  = 4'd0,
        OP_RET   = 4'd1,
        OP_BRK   = 4'd2,
        OP_RTI   = 4'd3,
        OP_PHA   = 4'd4,
        OP_PHP   = 4'd5,
        OP_PLA   = 4'd6,
        OP_PLP   = 4'd7,
        OP_RESET = 4'd8
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_PUSH_P,
        S_PUSH_A,
        S_VEC_LO,
        S_VEC_HI,
        S_PULL_P,
        S_PULL_LO,
        S_PULL_HI,
        S_PULL_A,
        S_FIN_PC,
        S_FIN_P,
        S_FIN_A
    } state_e;

endpackage

// File: rtl/stk_cmd_decode.sv
module stk_cmd_decode
    import stk_pkg::*;
#(
    parameter int N = CMD_N
) (
    input  logic [N-1:0]    cmd_i,
    output logic            valid_o,
    output logic [OP_W-1:0] op_o
);
    int ones;

    always_comb begin
        ones = 0;
        op_o = '0;
        for (int k = 0; k < N; k++) begin
            if (cmd_i[k]) begin
                ones = ones + 1;
                op_o = OP_W'(k);
            end
        end
        valid_o = (ones == 1);
    end
endmodule

// File: rtl/stk_status_pack.sv
module stk_status_pack
    import stk_pkg::*;
(
    input  flags_t             flags_i,
    output logic [DATA_W-1:0]  byte_o
);
    // break bit and bit 5 always read as one on the stack
    assign byte_o = {flags_i.n, flags_i.v, 1'b1, 1'b1,
                     flags_i.d, flags_i.i, flags_i.z, flags_i.c};
endmodule

// File: rtl/stk_status_unpack.sv
module stk_status_unpack
    import stk_pkg::*;
(
    input  logic [DATA_W-1:0] byte_i,
    output flags_t            flags_o
);
    logic [1:0] unused_bits;
    assign unused_bits = byte_i[5:4];

    always_comb begin
        flags_o.n = byte_i[7];
        flags_o.v = byte_i[6];
        flags_o.d = byte_i[3];
        flags_o.i = 1'b0;
        flags_o.z = byte_i[1];
        flags_o.c = byte_i[0];
    end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter logic [7:0]  SP_INIT    = 8'hFD,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_RESET  = 16'hFFFC,
    parameter logic [15:0] VEC_BREAK  = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cmd_i,
    input  logic [15:0] pc_i,
    input  logic [15:0] target_i,
    input  logic [7:0]  acc_i,
    input  logic [5:0]  flags_i,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    input  logic [7:0]  mem_rdata_i,
    output logic [7:0]  sp_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] pc_o,
    output logic        pc_load_o,
    output logic [5:0]  flags_o,
    output logic        flags_load_o,
    output logic [7:0]  acc_o,
    output logic        acc_load_o
);
    typedef struct packed {
        state_e                 state;
        op_e                    op;
        logic [DATA_W-1:0]      sp;
        logic [ADDR_W-1:0]      ret;
        logic [ADDR_W-1:0]      tgt;
        logic [DATA_W-1:0]      acc_in;
        flags_t                 flg;
        flags_t                 tmp;
        logic [DATA_W-1:0]      lo;
        logic [ADDR_W-1:0]      pc;
        flags_t                 flags;
        logic [DATA_W-1:0]      acc;
        logic                   done;
        logic                   pc_ld;
        logic                   fl_ld;
        logic                   acc_ld;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state:  S_VEC_LO,
        op:     OP_RESET,
        sp:     SP_INIT,
        default: '0
    };

    regs_t q, d;

    logic            cmd_ok;
    logic [OP_W-1:0] cmd_op;
    logic [7:0]      stat_byte;
    flags_t          pulled_flags;

    stk_cmd_decode #(.N(CMD_N)) u_dec (
        .cmd_i   (cmd_i),
        .valid_o (cmd_ok),
        .op_o    (cmd_op)
    );

    stk_status_pack u_pack (
        .flags_i (q.flg),
        .byte_o  (stat_byte)
    );

    stk_status_unpack u_unpack (
        .byte_i  (mem_rdata_i),
        .flags_o (pulled_flags)
    );

    logic [ADDR_W-1:0] stk_cur;
    logic [ADDR_W-1:0] stk_nxt;
    logic [ADDR_W-1:0] vec_base;
    logic [ADDR_W-1:0] pulled_word;

    assign stk_cur     = {STACK_PAGE, q.sp};
    assign stk_nxt     = {STACK_PAGE, q.sp + 8'd1};
    assign vec_base    = (q.op == OP_RESET) ? VEC_RESET : VEC_BREAK;
    assign pulled_word = {mem_rdata_i, q.lo};

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.pc_ld     = 1'b0;
        d.fl_ld     = 1'b0;
        d.acc_ld    = 1'b0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;

        unique case (q.state)
            S_IDLE: begin
                if (cmd_ok) begin
                    d.op     = op_e'(cmd_op);
                    d.ret    = pc_i - 16'd1;
                    d.tgt    = target_i;
                    d.acc_in = acc_i;
                    d.flg    = flags_t'(flags_i);
                    unique case (op_e'(cmd_op))
                        OP_CALL, OP_BRK: d.state = S_PUSH_HI;
                        OP_RET:          d.state = S_PULL_LO;
                        OP_RTI, OP_PLP:  d.state = S_PULL_P;
                        OP_PHA:          d.state = S_PUSH_A;
                        OP_PHP:          d.state = S_PUSH_P;
                        OP_PLA:          d.state = S_PULL_A;
                        default:         d.state = S_IDLE;
                    endcase
                end
            end
            S_PUSH_HI: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = stk_cur;
                mem_wdata_o = q.ret[15:8];
                d.sp        = q.sp - 8'd1;
                d.state     = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = stk_cur;
                mem_wdata_o = q.ret[7:0];
                d.sp        = q.sp - 8'd1;
                if (q.op == OP_CALL) begin
                    d.pc    = q.tgt;
                    d.pc_ld = 1'b1;
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.state = S_PUSH_P;
                end
            end
            S_PUSH_P: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = stk_cur;
                mem_wdata_o = stat_byte;
                d.sp        = q.sp - 8'd1;
                if (q.op == OP_BRK) begin
                    d.state = S_VEC_LO;
                end else begin
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end
            end
            S_PUSH_A: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = stk_cur;
                mem_wdata_o = q.acc_in;
                d.sp        = q.sp - 8'd1;
                d.done      = 1'b1;
                d.state     = S_IDLE;
            end
            S_VEC_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = vec_base;
                d.state    = S_VEC_HI;
            end
            S_VEC_HI: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = vec_base + 16'd1;
                d.lo       = mem_rdata_i;
                d.state    = S_FIN_PC;
            end
            S_PULL_P: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = stk_nxt;
                d.sp       = q.sp + 8'd1;
                d.state    = (q.op == OP_RTI) ? S_PULL_LO : S_FIN_P;
            end
            S_PULL_LO: begin
                if (q.op == OP_RTI) begin
                    d.tmp = pulled_flags;
                end
                mem_rd_o   = 1'b1;
                mem_addr_o = stk_nxt;
                d.sp       = q.sp + 8'd1;
                d.state    = S_PULL_HI;
            end
            S_PULL_HI: begin
                d.lo       = mem_rdata_i;
                mem_rd_o   = 1'b1;
                mem_addr_o = stk_nxt;
                d.sp       = q.sp + 8'd1;
                d.state    = S_FIN_PC;
            end
            S_PULL_A: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = stk_nxt;
                d.sp       = q.sp + 8'd1;
                d.state    = S_FIN_A;
            end
            S_FIN_PC: begin
                d.pc_ld = 1'b1;
                d.done  = 1'b1;
                d.state = S_IDLE;
                unique case (q.op)
                    OP_RET: d.pc = pulled_word + 16'd1;
                    OP_RTI: begin
                        d.pc    = pulled_word;
                        d.flags = q.tmp;
                        d.fl_ld = 1'b1;
                    end
                    OP_BRK: begin
                        d.pc      = pulled_word;
                        d.flags   = q.flg;
                        d.flags.i = 1'b1;
                        d.fl_ld   = 1'b1;
                    end
                    default: d.pc = pulled_word;
                endcase
            end
            S_FIN_P: begin
                d.flags = pulled_flags;
                d.fl_ld = 1'b1;
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            S_FIN_A: begin
                d.acc     = mem_rdata_i;
                d.acc_ld  = 1'b1;
                d.flags   = q.flg;
                d.flags.z = (mem_rdata_i == 8'd0);
                d.flags.n = mem_rdata_i[7];
                d.fl_ld   = 1'b1;
                d.done    = 1'b1;
                d.state   = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign sp_o         = q.sp;
    assign busy_o       = (q.state != S_IDLE);
    assign done_o       = q.done;
    assign pc_o         = q.pc;
    assign pc_load_o    = q.pc_ld;
    assign flags_o      = q.flags;
    assign flags_load_o = q.fl_ld;
    assign acc_o        = q.acc;
    assign acc_load_o   = q.acc_ld;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [15:0] mem_addr_o,
    input logic [7:0]  sp_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        pc_load_o,
    input logic        flags_load_o,
    input logic        acc_load_o
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_rd_o && !mem_wr_o)); // R11

    AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o == {STACK_PAGE, sp_o})); // R9

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> (sp_o == $past(sp_o) - 8'd1)); // R9

    AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && mem_addr_o[15:8] == STACK_PAGE) |=>
        (sp_o == $past(mem_addr_o[7:0]))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R12

    AST_LOAD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o || flags_load_o || acc_load_o) |-> done_o); // R12
endmodule

bind stk_seq stk_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .mem_addr_o   (mem_addr_o),
    .sp_o         (sp_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pc_load_o    (pc_load_o),
    .flags_load_o (flags_load_o),
    .acc_load_o   (acc_load_o)
);

// File: tb/sim_stk_seq.sv
`timescale 1ns/1ps
module sim_stk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] tgt = '0;
    logic [7:0]  acc_in = '0;
    logic [5:0]  fl_in = '0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  rdata = '0;
    logic [7:0]  sp_o;
    logic        busy_o, done_o, pc_load_o, flags_load_o, acc_load_o;
    logic [15:0] pc_o;
    logic [5:0]  flags_o;
    logic [7:0]  acc_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    stk_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .pc_i(pc_in), .target_i(tgt),
        .acc_i(acc_in), .flags_i(fl_in), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
        .sp_o(sp_o), .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o),
        .pc_load_o(pc_load_o), .flags_o(flags_o), .flags_load_o(flags_load_o),
        .acc_o(acc_o), .acc_load_o(acc_load_o)
    );

    // bus memory: stack page and vector bytes, one cycle read latency
    logic [7:0] smem [256];

    function automatic logic [7:0] vec_byte(input logic [1:0] idx);
        case (idx)
            2'd0: return 8'h34;
            2'd1: return 8'h12;
            2'd2: return 8'hCD;
            default: return 8'hAB;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) smem[i] <= 8'(i) ^ 8'h5A;
        end else if (mem_wr && mem_addr[15:8] == 8'h01) begin
            smem[mem_addr[7:0]] <= mem_wdata;
        end
        if (mem_rd) begin
            if (mem_addr[15:8] == 8'h01)       rdata <= smem[mem_addr[7:0]];
            else if (mem_addr[15:2] == 14'h3FFF) rdata <= vec_byte(mem_addr[1:0]);
            else                                 rdata <= 8'hEE;
        end
    end

    // independent model of the stack
    logic [7:0] mstk [256];
    logic [7:0] msp;

    function automatic logic [7:0] pack_st(input logic [5:0] f);
        return {f[5], f[4], 1'b1, 1'b1, f[3], f[2], f[1], f[0]};
    endfunction

    function automatic logic [5:0] unpack_st(input logic [7:0] b);
        return {b[7], b[6], b[3], 1'b0, b[1], b[0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_image(input string req);
        int bad = -1;
        for (int i = 0; i < 256; i++)
            if (bad < 0 && smem[i] !== mstk[i]) bad = i;
        if (bad < 0) chk(req, "stack image", 0, 0);
        else chk(req, "stack byte", {16'(bad), smem[bad], 8'h00}, {16'(bad), mstk[bad], 8'h00});
    endtask

    task automatic mpush(input logic [7:0] b);
        mstk[msp] = b;
        msp = msp - 8'd1;
    endtask

    task automatic mpull(output logic [7:0] b);
        msp = msp + 8'd1;
        b = mstk[msp];
    endtask

    // run one command; inject raises a push-acc request while busy
    task automatic run_cmd(input int op, input logic [15:0] pc, input logic [15:0] t,
                           input logic [7:0] a, input logic [5:0] f, input bit inject);
        logic [15:0] epc = '0;
        logic [15:0] r;
        logic [5:0]  efl = '0;
        logic [7:0]  eacc = '0, lo, hi, p;
        bit epl = 0, efl_l = 0, eacl = 0;
        int lat = 0, n = 0;
        bit got = 0;
        logic pl = 0, fll = 0, acl = 0;
        string req;
        r = pc - 16'd1;
        case (op)
            0: begin req = "R3"; mpush(r[15:8]); mpush(r[7:0]); epc = t; epl = 1; lat = 3; end
            1: begin req = "R4"; mpull(lo); mpull(hi); epc = {hi, lo} + 16'd1; epl = 1; lat = 4; end
            2: begin req = "R5"; mpush(r[15:8]); mpush(r[7:0]); mpush(pack_st(f));
                     epc = 16'hABCD; epl = 1; efl = f | 6'b000100; efl_l = 1; lat = 7; end
            3: begin req = "R6"; mpull(p); mpull(lo); mpull(hi); epc = {hi, lo}; epl = 1;
                     efl = unpack_st(p); efl_l = 1; lat = 5; end
            4: begin req = "R7"; mpush(a); lat = 2; end
            5: begin req = "R7"; mpush(pack_st(f)); lat = 2; end
            6: begin req = "R8"; mpull(p); eacc = p; eacl = 1; efl = f;
                     efl[1] = (p == 8'd0); efl[5] = p[7]; efl_l = 1; lat = 3; end
            default: begin req = "R8"; mpull(p); efl = unpack_st(p); efl_l = 1; lat = 3; end
        endcase
        cmd = 8'(1 << op); pc_in = pc; tgt = t; acc_in = a; fl_in = f;
        while (!got && n < 20) begin
            @(negedge clk);
            n++;
            cmd = (inject && n == 2) ? 8'h10 : 8'h00;
            if (done_o) begin
                got = 1; pl = pc_load_o; fll = flags_load_o; acl = acc_load_o;
            end
        end
        cmd = 8'h00;
        chk(req, "latency", n, lat);
        chk(req, "pc_load", 32'(pl), 32'(epl));
        chk(req, "flags_load", 32'(fll), 32'(efl_l));
        chk(req, "acc_load", 32'(acl), 32'(eacl));
        if (epl) chk(req, "pc", pc_o, epc);
        if (efl_l) chk((op == 3 || op == 7) ? "R2" : req, "flags", flags_o, efl);
        if (eacl) chk(req, "acc", acc_o, eacc);
        chk("R9", "sp", sp_o, msp);
        chk_image(op == 5 ? "R1" : "R9");
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed, n;
        seed = $urandom(32'd4711);
        for (int i = 0; i < 256; i++) mstk[i] = 8'(i) ^ 8'h5A;
        msp = 8'hFD;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "sp in reset", sp_o, 8'hFD);
        chk("R10", "done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        n = 0;
        while (!done_o && n < 10) begin @(negedge clk); n++; end
        chk("R10", "reset latency", n, 3);
        chk("R10", "reset pc", pc_o, 16'h1234);
        chk("R10", "reset pc_load", 32'(pc_load_o), 1);
        @(negedge clk);
        chk("R12", "done one cycle", 32'(done_o), 0);

        // R1 status packing extremes
        run_cmd(5, 0, 0, 0, 6'h3F, 0);
        run_cmd(5, 0, 0, 0, 6'h00, 0);
        // R2: pull a byte with bits 4,5 and I set
        run_cmd(4, 0, 0, 8'hFF, 0, 0);
        run_cmd(7, 0, 0, 0, 0, 0);
        run_cmd(4, 0, 0, 8'h34, 0, 0);
        run_cmd(7, 0, 0, 0, 6'h3F, 0);
        // R8 zero and negative pulls
        run_cmd(4, 0, 0, 8'h00, 0, 0);
        run_cmd(6, 0, 0, 0, 6'h3F, 0);
        run_cmd(4, 0, 0, 8'h80, 0, 0);
        run_cmd(6, 0, 0, 0, 6'h00, 0);
        // call/return pair, call at page boundary
        run_cmd(0, 16'h0300, 16'h4000, 0, 0, 0);
        run_cmd(1, 0, 0, 0, 0, 0);
        // break then interrupt return, with request injected while busy (R11)
        run_cmd(2, 16'h2222, 0, 0, 6'h2B, 1);
        run_cmd(3, 0, 0, 0, 0, 0);

        // R11 multi-hot and empty commands ignored
        cmd = 8'h03;
        @(negedge clk);
        cmd = 8'h00;
        chk("R11", "busy after multi-hot", 32'(busy_o), 0);
        chk("R11", "bus after multi-hot", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        chk("R11", "done after multi-hot", 32'(done_o), 0);
        chk("R11", "sp after multi-hot", sp_o, msp);

        // R9 wrap: 256 pushes then 256 pulls
        for (int i = 0; i < 256; i++) run_cmd(4, 0, 0, 8'(i * 7), 0, 0);
        for (int i = 0; i < 256; i++) run_cmd(6, 0, 0, 0, 6'(i), 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            run_cmd(int'($urandom % 8), 16'($urandom), 16'($urandom),
                    8'($urandom), 6'($urandom), ($urandom % 5) == 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule